// File: doc/BRIEF.md
# Standby Clock-Gating Controller

This block sits beside the CPU of a small microcontroller. It turns a halt request into one of three sleep depths and drives registered clock-enable outputs for the CPU, the internal oscillator and nine peripherals. A 2-bit depth code, sampled with the request, picks the depth. In the lightest depth a 9-bit keep mask, also sampled with the request, decides which peripheral clocks stay running. In the middle depth only the oscillator runs. In the deepest depth everything is gated, including the oscillator.

An enabled interrupt request (`wake`) or reset ends the sleep. Peripheral clocks and the oscillator return first, and the CPU clock returns one cycle later. Leaving the deepest depth re-enables the oscillator first. The controller then counts a warm-up of 2^N oscillator cycles before it releases any other clock. N is 8 plus a 4-bit warm-up field, saturating at 16, and the field is sampled when the deepest depth is entered. The block only gates clocks and never clears anything, so every gated block keeps its register contents.

Top module: `stby_ctrl`

## Requirements
- R1: After reset `cpu_ce`, `osc_ce` and all nine `per_ce` bits are 1, `halt_mode` is 00 and `rsv_flag` is 0.
- R2: A halt request with code 11 (light depth) and no `wake` in the same cycle updates the outputs at that clock edge:
  - `cpu_ce` becomes 0 and `osc_ce` stays 1.
  - `per_ce[i]` becomes `keep_mask[i]` as sampled at that edge.
  - `halt_mode` becomes 11.
  - Peripheral bit order: 0 = 8-bit timer pair A, 1 = 8-bit timer pair B, 2 = 16-bit timer 0, 3 = 16-bit timer 1, 4 = serial 0, 5 = serial 1, 6 = ADC, 7 = watchdog, 8 = serial bus interface.
- R3: A halt request with code 10 (middle depth) sets `cpu_ce` and all `per_ce` bits to 0, keeps `osc_ce` at 1 and sets `halt_mode` to 10.
- R4: A halt request with code 01 (deep depth) sets `cpu_ce`, `osc_ce` and all `per_ce` bits to 0, and sets `halt_mode` to 01.
- R5: A halt request with the reserved code 00 enters the light depth with every `per_ce` bit 0, whatever the mask. It sets `halt_mode` to 11 and `rsv_flag` to 1. The next entry with a nonzero code clears `rsv_flag`.
- R6: In the light or middle depth, `wake` sampled high at an edge sets `osc_ce` and all `per_ce` bits to 1 at that edge, with `cpu_ce` still 0. At the following edge `cpu_ce` becomes 1 and `halt_mode` becomes 00.
- R7: In the deep depth, `wake` sampled high at an edge sets only `osc_ce` to 1. The other enables stay 0 for the next 2^N - 1 edges, where N = min(8 + `warm_exp`, 16) and `warm_exp` is sampled at entry. All `per_ce` bits rise at the 2^N-th edge, and `cpu_ce` and `halt_mode` = 00 follow one edge later.
- R8: A halt request that sees `wake` high in the same cycle is abandoned, and every output keeps its running value.
- R9: While halted, changes of `keep_mask`, `mode_sel` and `warm_exp` and further halt requests have no effect on the outputs. So does `wake` during the warm-up.
- R10: Asserting `rst_n` low while halted restores the R1 output values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, also a wake source |
| halt_req | input | 1 | One-cycle halt request from the CPU |
| mode_sel | input | 2 | Depth code: 11 light, 10 middle, 01 deep, 00 reserved |
| keep_mask | input | 9 | Light-depth per-peripheral keep-running mask |
| warm_exp | input | 4 | Warm-up exponent offset (N = 8 + value, max 16) |
| wake | input | 1 | Enabled interrupt request ending a halt |
| cpu_ce | output | 1 | CPU clock enable |
| osc_ce | output | 1 | Oscillator enable |
| per_ce | output | 9 | Peripheral clock enables |
| halt_mode | output | 2 | Current depth code, 00 while running |
| rsv_flag | output | 1 | Set when the reserved code was used at entry |

## Verification
The bench sweeps all 512 keep masks through light-depth entry and wake. A design that sampled the mask late, or not at all, would show a wrong `per_ce` pattern at entry. All four depth codes are entered, and the reserved code is checked to gate every peripheral and to set, then clear, the flag. A design that passed the mask through for code 00 would leave clocks running. The deep-depth wake is timed for several exponents, including one above the saturation limit. A counter that is off by one, or that does not clamp, would release the clocks a cycle early or late, or after a far longer wait. Wake in the same cycle as the request, inputs that change while halted, and reset while halted are each checked at the outputs, because a design that got them wrong would visibly stop the CPU or change a running clock.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_LIGHT  = 3'd1,
    ST_MID    = 3'd2,
    ST_DEEP   = 3'd3,
    ST_WARM   = 3'd4,
    ST_RESUME = 3'd5
  } stby_state_e;

  localparam logic [1:0] CODE_RUN   = 2'b00;
  localparam logic [1:0] CODE_DEEP  = 2'b01;
  localparam logic [1:0] CODE_MID   = 2'b10;
  localparam logic [1:0] CODE_LIGHT = 2'b11;

  // depth code -> sleep state; the reserved code maps to the light depth
  function automatic stby_state_e code_to_state(input logic [1:0] code);
    case (code)
      CODE_DEEP: return ST_DEEP;
      CODE_MID:  return ST_MID;
      default:   return ST_LIGHT;
    endcase
  endfunction

  // code shown on halt_mode for an accepted entry
  function automatic logic [1:0] shown_code(input logic [1:0] code);
    return (code == CODE_RUN) ? CODE_LIGHT : code;
  endfunction

  // last counter value of the warm-up: 2^min(lo+e, hi) - 1
  function automatic int unsigned warm_last(input int unsigned e,
                                            input int unsigned lo,
                                            input int unsigned hi);
    int unsigned n;
    n = lo + e;
    if (n > hi) n = hi;
    return (32'd1 << n) - 32'd1;
  endfunction

endpackage

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        halt_req,
  input  logic [1:0]  mode_sel,
  input  logic        wake,
  input  logic        warm_done,
  output stby_state_e state_q,
  output stby_state_e state_nxt,
  output logic        enter_ev,
  output logic        cpu_ce,
  output logic        osc_ce,
  output logic [1:0]  halt_mode,
  output logic        rsv_flag
);

  logic abandon_ev;
  logic wake_ev;

  always_comb begin
    state_nxt  = state_q;
    enter_ev   = 1'b0;
    abandon_ev = 1'b0;
    wake_ev    = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (halt_req) begin
          if (wake) begin
            abandon_ev = 1'b1;
          end else begin
            enter_ev  = 1'b1;
            state_nxt = code_to_state(mode_sel);
          end
        end
      end
      ST_LIGHT, ST_MID: begin
        if (wake) begin
          wake_ev   = 1'b1;
          state_nxt = ST_RESUME;
        end
      end
      ST_DEEP: begin
        if (wake) begin
          wake_ev   = 1'b1;
          state_nxt = ST_WARM;
        end
      end
      ST_WARM:   if (warm_done) state_nxt = ST_RESUME;
      ST_RESUME: state_nxt = ST_RUN;
      default:   state_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      cpu_ce    <= 1'b1;
      osc_ce    <= 1'b1;
      halt_mode <= CODE_RUN;
      rsv_flag  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      cpu_ce  <= (state_nxt == ST_RUN);
      osc_ce  <= (state_nxt != ST_DEEP);
      if (enter_ev) begin
        halt_mode <= shown_code(mode_sel);
        rsv_flag  <= (mode_sel == CODE_RUN);
      end else if (state_nxt == ST_RUN) begin
        halt_mode <= CODE_RUN;
      end
    end
  end

  // R8
  abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abandon_ev |=> (cpu_ce && halt_mode == CODE_RUN));

  // R4
  deep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEEP) |-> (!osc_ce && !cpu_ce && halt_mode == CODE_DEEP));

  // R6
  wake_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_ev && state_q != ST_DEEP) |=> (osc_ce && !cpu_ce) ##1 cpu_ce);

  // R5
  rsv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_ev && mode_sel == CODE_RUN) |=> (rsv_flag && halt_mode == CODE_LIGHT));

endmodule

// File: rtl/stby_warm.sv
module stby_warm
  import stby_pkg::*;
#(
  parameter int unsigned MIN_EXP = 8,
  parameter int unsigned MAX_EXP = 16,
  parameter int unsigned EXP_W   = 4,
  localparam int unsigned CNT_W  = MAX_EXP
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_exp,
  input  logic [EXP_W-1:0] exp_in,
  input  logic             run,
  output logic             done
);

  logic [EXP_W-1:0] exp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_last;

  assign cnt_last = CNT_W'(warm_last(int'(exp_q), MIN_EXP, MAX_EXP));
  assign done     = run && (cnt_q == cnt_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_exp) exp_q <= exp_in;
      cnt_q <= run ? cnt_q + 1'b1 : '0;
    end
  end

  // R7
  warm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= cnt_last));

  // R7
  warm_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !run);

endmodule

// File: rtl/stby_gate.sv
module stby_gate
  import stby_pkg::*;
#(
  parameter int unsigned NPER = 9
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter_ev,
  input  logic            rsv_in,
  input  logic [NPER-1:0] keep_in,
  input  stby_state_e     state_q,
  input  stby_state_e     state_nxt,
  output logic [NPER-1:0] per_ce
);

  logic all_on;
  logic light_nxt;

  assign all_on    = (state_nxt == ST_RUN) || (state_nxt == ST_RESUME);
  assign light_nxt = (state_nxt == ST_LIGHT);

  for (genvar i = 0; i < NPER; i++) begin : g_lane
    logic keep_q;
    logic keep_now;
    assign keep_now = enter_ev ? (keep_in[i] && !rsv_in) : keep_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        keep_q    <= 1'b0;
        per_ce[i] <= 1'b1;
      end else begin
        keep_q    <= keep_now;
        per_ce[i] <= all_on || (light_nxt && keep_now);
      end
    end
  end

  // R3
  gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MID || state_q == ST_DEEP || state_q == ST_WARM) |-> (per_ce == '0));

  // R9
  keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LIGHT && $past(state_q) == ST_LIGHT) |-> $stable(per_ce));

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int unsigned NPER    = 9,
  parameter int unsigned MIN_EXP = 8,
  parameter int unsigned MAX_EXP = 16,
  parameter int unsigned EXP_W   = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic [1:0]       mode_sel,
  input  logic [NPER-1:0]  keep_mask,
  input  logic [EXP_W-1:0] warm_exp,
  input  logic             wake,
  output logic             cpu_ce,
  output logic             osc_ce,
  output logic [NPER-1:0]  per_ce,
  output logic [1:0]       halt_mode,
  output logic             rsv_flag
);

  stby_state_e state_q;
  stby_state_e state_nxt;
  logic        enter_ev;
  logic        warm_done;
  logic        warm_run;
  logic        load_exp;

  assign warm_run = (state_q == ST_WARM);
  assign load_exp = enter_ev && (mode_sel == CODE_DEEP);

  stby_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_req  (halt_req),
    .mode_sel  (mode_sel),
    .wake      (wake),
    .warm_done (warm_done),
    .state_q   (state_q),
    .state_nxt (state_nxt),
    .enter_ev  (enter_ev),
    .cpu_ce    (cpu_ce),
    .osc_ce    (osc_ce),
    .halt_mode (halt_mode),
    .rsv_flag  (rsv_flag)
  );

  stby_warm #(
    .MIN_EXP (MIN_EXP),
    .MAX_EXP (MAX_EXP),
    .EXP_W   (EXP_W)
  ) u_warm (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_exp (load_exp),
    .exp_in   (warm_exp),
    .run      (warm_run),
    .done     (warm_done)
  );

  stby_gate #(
    .NPER (NPER)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_ev  (enter_ev),
    .rsv_in    (mode_sel == CODE_RUN),
    .keep_in   (keep_mask),
    .state_q   (state_q),
    .state_nxt (state_nxt),
    .per_ce    (per_ce)
  );

  // R6
  cpu_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ce) |-> ($past(osc_ce) && (&$past(per_ce))));

  // R2
  cpu_halt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce |-> (halt_mode != CODE_RUN));

endmodule

// File: tb/stby_ctrl_tb_top.sv
module stby_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_req = 1'b0;
  logic [1:0] mode_sel = 2'b11;
  logic [8:0] keep_mask = '0;
  logic [3:0] warm_exp = '0;
  logic       wake = 1'b0;
  logic       cpu_ce, osc_ce, rsv_flag;
  logic [8:0] per_ce;
  logic [1:0] halt_mode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_req  (halt_req),
    .mode_sel  (mode_sel),
    .keep_mask (keep_mask),
    .warm_exp  (warm_exp),
    .wake      (wake),
    .cpu_ce    (cpu_ce),
    .osc_ce    (osc_ce),
    .per_ce    (per_ce),
    .halt_mode (halt_mode),
    .rsv_flag  (rsv_flag)
  );

  // packed view {cpu, osc, per[8:0], mode[1:0]}
  function automatic logic [12:0] pack(input logic c, input logic o,
                                       input logic [8:0] p, input logic [1:0] m);
    return {c, o, p, m};
  endfunction

  task automatic check(input string req, input logic [12:0] exp_v);
    logic [12:0] act;
    act = pack(cpu_ce, osc_ce, per_ce, halt_mode);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic check_flag(input string req, input logic exp_f);
    checks++;
    if (rsv_flag !== exp_f) begin
      errors++;
      $display("FAIL %s: rsv_flag got %b expected %b", req, rsv_flag, exp_f);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter(input logic [1:0] code, input logic [8:0] keep, input logic [3:0] e);
    halt_req = 1'b1; mode_sel = code; keep_mask = keep; warm_exp = e;
    tick();
    halt_req = 1'b0;
  endtask

  task automatic wake_pulse();
    wake = 1'b1;
    tick();
    wake = 1'b0;
  endtask

  localparam logic [12:0] RUNV = {1'b1, 1'b1, 9'h1FF, 2'b00};

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", RUNV);
    check_flag("R1", 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1", RUNV);

    // R2 / R6: sweep every keep mask through light entry and wake
    for (int k = 0; k < 512; k++) begin
      enter(2'b11, 9'(k), 4'd0);
      keep_mask = ~9'(k);
      check("R2", pack(1'b0, 1'b1, 9'(k), 2'b11));
      wake_pulse();
      check("R6", pack(1'b0, 1'b1, 9'h1FF, 2'b11));
      tick();
      check("R6", RUNV);
    end

    // R3 middle depth, then wake
    enter(2'b10, 9'h1FF, 4'd0);
    check("R3", pack(1'b0, 1'b1, 9'h000, 2'b10));
    wake_pulse();
    check("R6", pack(1'b0, 1'b1, 9'h1FF, 2'b10));
    tick();
    check("R6", RUNV);

    // R5 reserved code gates all peripherals and sets the flag
    enter(2'b00, 9'h1FF, 4'd0);
    check("R5", pack(1'b0, 1'b1, 9'h000, 2'b11));
    check_flag("R5", 1'b1);
    wake_pulse(); tick();
    check("R5", RUNV);
    check_flag("R5", 1'b1);
    enter(2'b10, 9'h000, 4'd0);
    check_flag("R5", 1'b0);
    wake_pulse(); tick();

    // R9 inputs ignored while in light depth
    enter(2'b11, 9'h0A5, 4'd0);
    keep_mask = 9'h15A; mode_sel = 2'b01; warm_exp = 4'd3;
    tick();
    halt_req = 1'b1; tick(); halt_req = 1'b0;
    check("R9", pack(1'b0, 1'b1, 9'h0A5, 2'b11));
    wake_pulse(); tick();
    check("R9", RUNV);

    // R8 wake in the same cycle as the request
    halt_req = 1'b1; wake = 1'b1; mode_sel = 2'b01;
    tick();
    halt_req = 1'b0; wake = 1'b0;
    check("R8", RUNV);
    tick();
    check("R8", RUNV);

    // R4 / R7 deep depth with several exponents (15 saturates at 2^16)
    for (int t = 0; t < 4; t++) begin
      int e;
      int len;
      e = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 3 : 15;
      len = 1 << ((8 + e > 16) ? 16 : 8 + e);
      enter(2'b01, 9'h1FF, 4'(e));
      warm_exp = 4'd0;
      check("R4", pack(1'b0, 1'b0, 9'h000, 2'b01));
      tick();
      check("R4", pack(1'b0, 1'b0, 9'h000, 2'b01));
      wake_pulse();
      check("R7", pack(1'b0, 1'b1, 9'h000, 2'b01));
      if (t == 0) wake = 1'b1;   // R9 wake during warm-up is ignored
      repeat (len - 1) tick();
      wake = 1'b0;
      check("R7", pack(1'b0, 1'b1, 9'h000, 2'b01));
      tick();
      check("R7", pack(1'b0, 1'b1, 9'h1FF, 2'b01));
      tick();
      check("R7", RUNV);
    end

    // R10 asynchronous reset while halted
    enter(2'b01, 9'h000, 4'd0);
    check("R10", pack(1'b0, 1'b0, 9'h000, 2'b01));
    #2 rst_n = 1'b0;
    #1 check("R10", RUNV);
    check_flag("R10", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R10", RUNV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule